// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block turns one vectorised instruction into a stream of element operations. A start pulse loads the vector length, the base register numbers of the source and destination, a scalar/vector tag for each operand, the predicate masks, a twin-predication enable and the operation class. The sequencer then walks the element positions in ascending order. For each element it offers the execution unit a source and a destination register number. A one-cycle done pulse marks the end of the instruction.

A vector-tagged operand steps its register offset with the element position. A scalar-tagged operand keeps offset zero. When either operand is scalar, the loop ends after its first issued operation. With a single predicate this gives gather (scalar destination) and scatter (scalar source). Twin predication gives each side its own mask and its own position. It is accepted only for data-movement classes and refused for arithmetic. No check is made on overlapping register ranges.

Top module: `twin_pred_seq`

## Requirements
- R1: While reset is held and after it is released, `el_valid` and `done` are low until a start is accepted.
- R2: A register number is (base + offset) modulo `REGS`, so it wraps past the last register. A vector operand's offset is its element position and a scalar operand's offset is 0.
- R3: With both operands vector, `pred_en`=0 and `twin_en`=0, exactly `vlen` operations issue in ascending order: (src_base+i, dst_base+i) for i = 0 .. vlen-1.
- R4: With `pred_en`=1 and `twin_en`=0, bit i of `src_mask` gates element i for both sides, and `dst_mask` is ignored. A masked-off element advances both positions and issues nothing.
- R5: A scalar destination with `pred_en`=0 issues exactly one operation, (src_base, dst_base), followed by done.
- R6: Gather (vector source, scalar destination, predicate on) issues one operation (src_base+k, dst_base), where k is the lowest set bit of `src_mask` below `vlen`.
- R7: Scatter (scalar source, vector destination, predicate on) issues one operation (src_base, dst_base+k), where k is the lowest set bit of `src_mask` below `vlen`.
- R8: With `twin_en`=1 and an allowed class, each vector side moves on its own to the next set bit of its own mask (`src_mask` or `dst_mask`). A scalar side counts as always set and does not move. An operation issues only when both sides are set, and the loop ends when either position reaches `vlen`.
- R9: `op_class` codes are 0 arithmetic, 1 move, 2 load, 3 store and 4 sign-extend. A start with `twin_en`=1 and a class other than 1..4 issues no operation and gives done with `refused`=1 in the next cycle.
- R10: A start with `vlen`=0, or a predicate with no set bit below `vlen`, ends with done and zero operations. `refused` stays 0 in that case.
- R11: An offered operation keeps its register numbers until `el_ready` is high. `done` is a single-cycle pulse in the cycle after the final acceptance or termination.
- R12: Overlapping source and destination ranges cause no stall. With `el_ready` held high and no masked element, one operation is accepted per cycle and done follows `vlen` cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction; taken only when idle |
| vlen | input | $clog2(MAX_VL+1) | Vector length |
| src_base | input | $clog2(REGS) | Source base register |
| dst_base | input | $clog2(REGS) | Destination base register |
| src_vec | input | 1 | 1 = source is vector, 0 = scalar |
| dst_vec | input | 1 | 1 = destination is vector, 0 = scalar |
| pred_en | input | 1 | Apply predicate masks |
| src_mask | input | MAX_VL | Source (or shared) predicate, bit i for element i |
| dst_mask | input | MAX_VL | Destination predicate, used under twin predication |
| twin_en | input | 1 | Request independent source/destination predicates |
| op_class | input | 3 | Operation class code |
| el_ready | input | 1 | Execution unit accepts the offered operation |
| el_valid | output | 1 | An element operation is offered |
| el_src | output | $clog2(REGS) | Source register number |
| el_dst | output | $clog2(REGS) | Destination register number |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| refused | output | 1 | Qualifies done: twin predication rejected |

## Verification
The vector table runs the same loop with all-vector operands and no predicate, then with a sparse shared mask. Comparing the two shows whether skipping advances both positions together. It also runs scalar-destination and scalar-source patterns with the first set bit at different positions, which tells gather apart from scatter and from the unpredicated single issue. Twin patterns with differently populated source and destination masks show whether each side advances on its own and whether the loop ends on whichever side runs out first. The arithmetic and out-of-range class codes test the refusal path. Empty masks, zero length, wrapped base registers and stalled `el_ready` patterns cover termination without issue, the modulo register number and hold-until-accepted.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [2:0] {
    OPC_ARITH = 3'd0,
    OPC_MOVE  = 3'd1,
    OPC_LOAD  = 3'd2,
    OPC_STORE = 3'd3,
    OPC_SEXT  = 3'd4
  } opc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;

  // Only data-movement classes may use independent predicates.
  function automatic logic twin_allowed(input logic [2:0] cls);
    return (cls == OPC_MOVE) || (cls == OPC_LOAD) ||
           (cls == OPC_STORE) || (cls == OPC_SEXT);
  endfunction

endpackage

// File: rtl/tps_cursor.sv
module tps_cursor #(
  parameter int MAX_VL = 16,
  parameter int VLW    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [MAX_VL-1:0] mask,
  input  logic [VLW-1:0]    vl,
  output logic [VLW-1:0]    pos,
  output logic              hit,
  output logic              end_next
);
  localparam int IW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

  logic [VLW-1:0] pos_d;
  logic           pos_en;
  logic [VLW:0]   pos_nxt;

  assign pos_nxt  = {1'b0, pos} + {{VLW{1'b0}}, step};
  assign end_next = pos_nxt >= {1'b0, vl};
  assign hit      = (pos < vl) && mask[pos[IW-1:0]];

  always_comb begin
    pos_en = load | step;
    pos_d  = pos;
    if (load)      pos_d = '0;
    else if (step) pos_d = pos_nxt[VLW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (pos_en) pos <= pos_d;
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> pos < vl); // R3

endmodule

// File: rtl/tps_regmap.sv
module tps_regmap #(
  parameter int VLW = 5,
  parameter int RW  = 6
) (
  input  logic [RW-1:0]  base,
  input  logic [VLW-1:0] pos,
  input  logic           is_vec,
  output logic [RW-1:0]  regnum
);
  logic [RW-1:0] offset;

  generate
    if (VLW > RW) begin : g_trunc
      assign offset = is_vec ? pos[RW-1:0] : '0;
    end else begin : g_ext
      assign offset = is_vec ? {{(RW-VLW){1'b0}}, pos} : '0;
    end
  endgenerate

  // Sum truncated to RW bits: modulo a power-of-two register file.
  assign regnum = base + offset;

endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq
  import tps_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int REGS   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(MAX_VL+1)-1:0] vlen,
  input  logic [$clog2(REGS)-1:0]    src_base,
  input  logic [$clog2(REGS)-1:0]    dst_base,
  input  logic                       src_vec,
  input  logic                       dst_vec,
  input  logic                       pred_en,
  input  logic [MAX_VL-1:0]          src_mask,
  input  logic [MAX_VL-1:0]          dst_mask,
  input  logic                       twin_en,
  input  logic [2:0]                 op_class,
  input  logic                       el_ready,
  output logic                       el_valid,
  output logic [$clog2(REGS)-1:0]    el_src,
  output logic [$clog2(REGS)-1:0]    el_dst,
  output logic                       done,
  output logic                       refused
);
  localparam int VLW = $clog2(MAX_VL + 1);
  localparam int RW  = $clog2(REGS);

  // ---------------- latched instruction ----------------
  logic [VLW-1:0]    cfg_vl;
  logic [RW-1:0]     cfg_sb, cfg_db;
  logic              cfg_sv, cfg_dv, cfg_twin;
  logic [MAX_VL-1:0] cfg_sm, cfg_dm;

  seq_st_e st_q, st_d;
  logic    done_d, refused_d;

  logic              start_ok, refuse, zero_len, load;
  logic [MAX_VL-1:0] pred_base, sm_eff, dm_eff, dmask_own;

  logic           run, issue, acc, scalar_any, fin;
  logic           s_step, d_step, s_hit, d_hit, s_end, d_end;
  logic [VLW-1:0] s_pos, d_pos;

  // ---------------- start decode ----------------
  always_comb begin
    start_ok  = (st_q == ST_IDLE) && start;
    refuse    = twin_en && !twin_allowed(op_class);
    zero_len  = (vlen == '0);
    load      = start_ok && !refuse && !zero_len;
    pred_base = pred_en ? src_mask : '1;
    dmask_own = pred_en ? dst_mask : '1;
    if (twin_en) begin
      sm_eff = src_vec ? pred_base : '1;
      dm_eff = dst_vec ? dmask_own : '1;
    end else begin
      sm_eff = pred_base;
      dm_eff = pred_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_vl   <= '0;
      cfg_sb   <= '0;
      cfg_db   <= '0;
      cfg_sv   <= 1'b0;
      cfg_dv   <= 1'b0;
      cfg_twin <= 1'b0;
      cfg_sm   <= '0;
      cfg_dm   <= '0;
    end else if (start_ok) begin
      cfg_vl   <= vlen;
      cfg_sb   <= src_base;
      cfg_db   <= dst_base;
      cfg_sv   <= src_vec;
      cfg_dv   <= dst_vec;
      cfg_twin <= twin_en;
      cfg_sm   <= sm_eff;
      cfg_dm   <= dm_eff;
    end
  end

  // ---------------- per-side cursors ----------------
  tps_cursor #(.MAX_VL(MAX_VL), .VLW(VLW)) u_src_cur (
    .clk(clk), .rst_n(rst_n), .load(load), .step(s_step),
    .mask(cfg_sm), .vl(cfg_vl), .pos(s_pos), .hit(s_hit), .end_next(s_end)
  );

  tps_cursor #(.MAX_VL(MAX_VL), .VLW(VLW)) u_dst_cur (
    .clk(clk), .rst_n(rst_n), .load(load), .step(d_step),
    .mask(cfg_dm), .vl(cfg_vl), .pos(d_pos), .hit(d_hit), .end_next(d_end)
  );

  tps_regmap #(.VLW(VLW), .RW(RW)) u_src_map (
    .base(cfg_sb), .pos(s_pos), .is_vec(cfg_sv), .regnum(el_src)
  );

  tps_regmap #(.VLW(VLW), .RW(RW)) u_dst_map (
    .base(cfg_db), .pos(d_pos), .is_vec(cfg_dv), .regnum(el_dst)
  );

  // ---------------- loop control ----------------
  always_comb begin
    run        = (st_q == ST_RUN);
    issue      = s_hit && d_hit;
    el_valid   = run && issue;
    acc        = el_valid && el_ready;
    scalar_any = !cfg_sv || !cfg_dv;
    if (cfg_twin) begin
      s_step = run && cfg_sv && (issue ? acc : !s_hit);
      d_step = run && cfg_dv && (issue ? acc : !d_hit);
    end else begin
      s_step = run && (!issue || acc);
      d_step = s_step;
    end
    fin = run && ((acc && scalar_any) || s_end || d_end);
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (load) st_d = ST_RUN;
      ST_RUN:  if (fin)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    done_d    = (start_ok && (refuse || zero_len)) || fin;
    refused_d = start_ok && refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done    <= 1'b0;
      refused <= 1'b0;
    end else begin
      st_q    <= st_d;
      done    <= done_d;
      refused <= refused_d;
    end
  end

  // ---------------- assertions ----------------
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && !el_ready |=> el_valid && $stable(el_src) && $stable(el_dst)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !el_valid); // R11

  AST_REFUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> done && !el_valid); // R9

  AST_SCALAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    el_valid && el_ready && (!cfg_sv || !cfg_dv) |=> done); // R5

endmodule

// File: tb/twin_pred_seq_test.sv
`timescale 1ns/1ps
module twin_pred_seq_test;
  localparam int MAX_VL = 16;
  localparam int REGS   = 64;
  localparam int VLW    = 5;
  localparam int RW     = 6;

  typedef struct packed {
    logic [4:0]  vl;
    logic [5:0]  sb;
    logic [5:0]  db;
    logic        sv;
    logic        dv;
    logic        pred;
    logic        twin;
    logic [2:0]  cls;
    logic [15:0] sm;
    logic [15:0] dm;
    logic [1:0]  rdy;   // 0 always ready, 1 every third cycle low, 2 low for first five
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{5'd6, 6'd2,  6'd10, 1'b1,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h0000,2'd1,8'd3},  // R3
    '{5'd8, 6'd0,  6'd20, 1'b1,1'b1,1'b1,1'b0,3'd0,16'h002D,16'hFFFF,2'd1,8'd4},  // R4
    '{5'd8, 6'd7,  6'd9,  1'b1,1'b0,1'b0,1'b0,3'd0,16'h0000,16'h0000,2'd2,8'd5},  // R5
    '{5'd8, 6'd8,  6'd3,  1'b1,1'b0,1'b1,1'b0,3'd0,16'h0024,16'h0000,2'd0,8'd6},  // R6
    '{5'd8, 6'd1,  6'd30, 1'b0,1'b1,1'b1,1'b0,3'd0,16'h0010,16'h0000,2'd1,8'd7},  // R7
    '{5'd8, 6'd0,  6'd16, 1'b1,1'b1,1'b1,1'b1,3'd1,16'h00A5,16'h00F0,2'd1,8'd8},  // R8
    '{5'd8, 6'd0,  6'd0,  1'b1,1'b1,1'b1,1'b1,3'd0,16'h00FF,16'h00FF,2'd0,8'd9},  // R9
    '{5'd8, 6'd0,  6'd0,  1'b1,1'b1,1'b1,1'b1,3'd5,16'h00FF,16'h00FF,2'd0,8'd9},  // R9
    '{5'd8, 6'd4,  6'd4,  1'b1,1'b1,1'b1,1'b0,3'd0,16'hFF00,16'h0000,2'd0,8'd10}, // R10
    '{5'd0, 6'd4,  6'd4,  1'b1,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h0000,2'd0,8'd10}, // R10
    '{5'd5, 6'd62, 6'd60, 1'b1,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h0000,2'd0,8'd2},  // R2
    '{5'd8, 6'd5,  6'd40, 1'b0,1'b1,1'b1,1'b1,3'd3,16'h0000,16'h0008,2'd1,8'd8},  // R8
    '{5'd4, 6'd4,  6'd5,  1'b1,1'b1,1'b0,1'b0,3'd0,16'h0000,16'h0000,2'd0,8'd12}, // R12
    '{5'd4, 6'd10, 6'd50, 1'b1,1'b1,1'b1,1'b1,3'd2,16'h0003,16'h0001,2'd0,8'd8}   // R8
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [VLW-1:0] vlen;
  logic [RW-1:0]  src_base, dst_base;
  logic src_vec, dst_vec, pred_en, twin_en, el_ready;
  logic [MAX_VL-1:0] src_mask, dst_mask;
  logic [2:0] op_class;
  logic el_valid, done, refused;
  logic [RW-1:0] el_src, el_dst;

  always #2.5 clk = ~clk;

  twin_pred_seq #(.MAX_VL(MAX_VL), .REGS(REGS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .src_base(src_base), .dst_base(dst_base), .src_vec(src_vec), .dst_vec(dst_vec),
    .pred_en(pred_en), .src_mask(src_mask), .dst_mask(dst_mask), .twin_en(twin_en),
    .op_class(op_class), .el_ready(el_ready), .el_valid(el_valid),
    .el_src(el_src), .el_dst(el_dst), .done(done), .refused(refused)
  );

  int errs = 0;
  int checks = 0;
  int exp_n;
  bit exp_ref;
  int exp_s [16];
  int exp_d [16];
  int last_cyc;

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int rmod(input int x);
    return x % REGS;
  endfunction

  // Reference sequence derived from the requirements.
  task automatic model(input vec_t v);
    int si, di;
    bit sm, dm, allowed;
    exp_n = 0;
    allowed = (v.cls >= 1) && (v.cls <= 4);
    exp_ref = v.twin && !allowed;
    if (exp_ref) return;
    if (!v.twin) begin
      for (int i = 0; i < int'(v.vl); i++) begin
        sm = v.pred ? v.sm[i] : 1'b1;
        if (sm) begin
          exp_s[exp_n] = rmod(int'(v.sb) + (v.sv ? i : 0));
          exp_d[exp_n] = rmod(int'(v.db) + (v.dv ? i : 0));
          exp_n++;
          if (!v.sv || !v.dv) break;
        end
      end
    end else begin
      si = 0; di = 0;
      while (si < int'(v.vl) && di < int'(v.vl)) begin
        sm = !v.sv ? 1'b1 : (v.pred ? v.sm[si] : 1'b1);
        dm = !v.dv ? 1'b1 : (v.pred ? v.dm[di] : 1'b1);
        if (sm && dm) begin
          exp_s[exp_n] = rmod(int'(v.sb) + (v.sv ? si : 0));
          exp_d[exp_n] = rmod(int'(v.db) + (v.dv ? di : 0));
          exp_n++;
          if (!v.sv || !v.dv) break;
          si++; di++;
        end else begin
          if (!sm) si++;
          if (!dm) di++;
        end
      end
    end
  endtask

  task automatic run_vec(input vec_t v);
    int got, cyc, req;
    bit seen_done, prev_hold, rd;
    logic [RW-1:0] ps, pd;
    req = int'(v.req);
    model(v);
    @(negedge clk);
    vlen = v.vl; src_base = v.sb; dst_base = v.db; src_vec = v.sv; dst_vec = v.dv;
    pred_en = v.pred; twin_en = v.twin; op_class = v.cls;
    src_mask = v.sm; dst_mask = v.dm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // Scramble inputs: the instruction must already be latched.
    src_base = ~v.sb; dst_base = ~v.db; src_mask = ~v.sm; dst_mask = ~v.dm;
    got = 0; cyc = 0; seen_done = 0; prev_hold = 0; rd = 0; ps = '0; pd = '0;
    while (!seen_done && cyc < 300) begin
      case (v.rdy)
        2'd1:    el_ready = (cyc % 3) != 1;
        2'd2:    el_ready = cyc >= 5;
        default: el_ready = 1'b1;
      endcase
      if (prev_hold)
        chk(el_valid && el_src == ps && el_dst == pd, 11, "offer held while not ready",
            int'(el_src), int'(ps));
      prev_hold = 0;
      if (done) begin
        seen_done = 1;
        rd = refused;
        chk(!el_valid, 11, "no offer with done", int'(el_valid), 0);
      end else if (el_valid) begin
        if (el_ready) begin
          if (got < exp_n) begin
            chk(el_src == RW'(exp_s[got]), req, "element src", int'(el_src), exp_s[got]);
            chk(el_dst == RW'(exp_d[got]), req, "element dst", int'(el_dst), exp_d[got]);
          end else begin
            chk(1'b0, req, "extra element", got + 1, exp_n);
          end
          got++;
        end else begin
          prev_hold = 1; ps = el_src; pd = el_dst;
        end
      end
      if (!seen_done) begin
        cyc++;
        @(negedge clk);
      end
    end
    last_cyc = cyc;
    chk(seen_done, 11, "done reached", int'(seen_done), 1);
    chk(got == exp_n, req, "element count", got, exp_n);
    chk(rd == exp_ref, 9, "refused flag", int'(rd), int'(exp_ref));
    @(negedge clk);
    chk(!done, 11, "done single cycle", int'(done), 0);
    el_ready = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vlen = '0; src_base = '0; dst_base = '0;
    src_vec = 1'b1; dst_vec = 1'b1; pred_en = 1'b0; twin_en = 1'b0;
    op_class = 3'd0; src_mask = '0; dst_mask = '0; el_ready = 1'b1;
    repeat (2) @(negedge clk);
    // R1: quiet during reset
    chk(!el_valid && !done, 1, "outputs during reset", int'(el_valid) + int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: quiet after reset without start
    chk(!el_valid && !done && !refused, 1, "idle after reset",
        int'(el_valid) + int'(done) + int'(refused), 0);

    for (int k = 0; k < NV; k++) run_vec(TBL[k]);

    // R12: overlapping ranges, always ready, no mask -> done after vlen cycles
    run_vec(TBL[12]);
    chk(last_cyc == 4, 12, "cycles start to done", last_cyc, 4);

    // R5: scalar destination, no predicate, long stall then one element only
    run_vec('{5'd3, 6'd63, 6'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0,
              16'h0000, 16'h0000, 2'd2, 8'd5});
    // R6: gather with first set bit at the last element
    run_vec('{5'd16, 6'd0, 6'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0,
              16'h8000, 16'h0000, 2'd1, 8'd6});
    // R10: twin predication whose destination mask is empty
    run_vec('{5'd6, 6'd0, 6'd8, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4,
              16'h003F, 16'h0000, 2'd0, 8'd10});

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule